// File: doc/BRIEF.md
# Four-Phase Instruction Cycle Sequencer

This block paces instruction execution in a small core that uses 14-bit instruction words. It splits the oscillator clock into instruction cycles of four phases each and drives one strobe for each phase. At the end of phase 4 it latches the word that the fetch path presents. During the following cycle it classifies that word and decodes its operand fields. Its outputs are the class, the file address, the bit position, the literal, the destination select and two write enables, one for the working register and one for the file register.

When the execute stage reports a taken skip or a program-counter change, it raises a flush request. The sequencer samples that request only at the phase-4 boundary. The whole next cycle then runs as an inserted NOP: the class reads NOP, both write enables stay low, and a flush indication is high for all four phases. The ALU, register file, stack and program memory sit outside the block.

Top module: `insn_cycle_seq`

## Requirements
- R1: Exactly one bit of phaseStb is high at all times. On each clock it steps from bit 0 (phase 1) to bit 1, then bit 2, then bit 3 (phase 4), and then back to bit 0.
- R2: fetchWord is captured only on the clock edge that ends phase 4. The decoded outputs show that word from the next phase 1, and they hold it through all four phases of that cycle no matter how fetchWord changes.
- R3: The class comes from word bits 13:12: 00 gives byte-oriented, 01 gives bit-oriented, 10 gives long jump and 11 gives literal. The codes on insnClass are NOP=0, BYTE=1, BIT=2, LIT=3 and JUMP=4.
- R4: fileAddr always carries word bits 6:0 and destFile always carries bit 7. For a byte-oriented word, wrW equals the inverse of bit 7 and wrFile equals bit 7. wrW and wrFile are never high together.
- R5: bitPos always carries word bits 9:7. A bit-oriented word with bit 11 equal to 0 (bits 11:10 = 00 or 01) raises wrFile. A bit-oriented word with bit 11 equal to 1 raises no write.
- R6: When bits 13:12 = 10, literal carries bits 10:0. For any other word it carries bits 7:0 zero-extended. A literal-class word raises wrW only. A long-jump word raises no write.
- R7: A word with bits 13:8 = 000000 and bit 7 = 0 decodes as NOP with no write. So does a word with bits 13:8 = 111011.
- R8: If flushReq is high on the edge that ends phase 4, the next cycle shows class NOP, wrW = 0 and wrFile = 0, and flushCycle is high for all four of its phases. flushReq in phases 1 to 3 has no effect.
- R9: While rst is high on a clock edge, the phase returns to phase 1, the latched word becomes 0x0000 (a NOP), and flushCycle clears. rst is synchronous and active high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous reset, active high |
| fetchWord | input | 14 | Instruction word from the fetch path |
| flushReq | input | 1 | Execute-stage request to squash the next cycle |
| phaseStb | output | 4 | One-hot phase strobes, bit 0 = phase 1 |
| insnClass | output | 3 | Decoded class code |
| fileAddr | output | 7 | File register address field |
| bitPos | output | 3 | Bit position field |
| literal | output | 11 | Immediate value or jump target |
| destFile | output | 1 | Destination select bit |
| wrW | output | 1 | Write enable for the working register |
| wrFile | output | 1 | Write enable for the file register |
| flushCycle | output | 1 | High during an inserted NOP cycle |

## Verification
The phase strobes change on every clock, and the bench checks them at every falling edge. A word and a flush request applied in phase 4 pass through one register each, so their decoded results are due at the falling edge of the next phase 1, and the bench samples them there. Each result is checked again at the falling edge of phase 3 of the same cycle to confirm that it is held. The bench drives scrambled words and flush requests during phases 1 to 3 and applies the real values only in phase 4, so any sampling outside the phase-4 edge shows up as a mismatch.

// File: rtl/insn_seq_pkg.sv
package insn_seq_pkg;
  localparam int WORD_W = 14;
  localparam int PHASES = 4;
  localparam int ADDR_W = 7;
  localparam int BITP_W = 3;
  localparam int LIT_W  = 11;

  typedef enum logic [2:0] {
    CLS_NOP  = 3'd0,
    CLS_BYTE = 3'd1,
    CLS_BIT  = 3'd2,
    CLS_LIT  = 3'd3,
    CLS_JUMP = 3'd4
  } insn_class_e;

  typedef struct packed {
    logic loadIr;
    logic squash;
  } seq_ctl_t;
endpackage

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import insn_seq_pkg::*;
#(
  parameter int NUM_PH = PHASES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flushReq,
  output logic [NUM_PH-1:0] phaseStb,
  output seq_ctl_t          ctl
);
  localparam int PH_W = (NUM_PH > 1) ? $clog2(NUM_PH) : 1;

  logic [PH_W-1:0] phase;
  logic lastPhase;
  logic flushActive;

  assign lastPhase = (phase == PH_W'(NUM_PH - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      phase       <= '0;
      flushActive <= 1'b0;
    end else begin
      phase <= lastPhase ? '0 : phase + 1'b1;
      if (lastPhase) flushActive <= flushReq;
    end
  end

  for (genvar g = 0; g < NUM_PH; g++) begin : g_stb
    assign phaseStb[g] = (phase == PH_W'(g));
  end

  assign ctl.loadIr = lastPhase;
  assign ctl.squash = flushActive;

  // R1: one strobe at a time, stepping and wrapping
  p_one_phase_r1: assert property (@(posedge clk) disable iff (rst)
    $countones(phaseStb) == 1);
  p_wrap_r1: assert property (@(posedge clk) disable iff (rst)
    phaseStb[NUM_PH-1] |=> phaseStb[0]);
  p_step_r1: assert property (@(posedge clk) disable iff (rst)
    phaseStb[0] |=> phaseStb[1]);
  // R8: flush state only changes at the cycle boundary
  p_flush_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !phaseStb[NUM_PH-1] |=> $stable(ctl.squash));
endmodule

// File: rtl/seq_dpath.sv
module seq_dpath
  import insn_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] fetchWord,
  input  seq_ctl_t          ctl,
  output logic [2:0]        insnClass,
  output logic [ADDR_W-1:0] fileAddr,
  output logic [BITP_W-1:0] bitPos,
  output logic [LIT_W-1:0]  literal,
  output logic              destFile,
  output logic              wrW,
  output logic              wrFile
);
  localparam logic [WORD_W-1:0] NOP_WORD = '0;
  localparam logic [3:0] LIT_HOLE = 4'b1011;

  logic [WORD_W-1:0] ir;
  insn_class_e rawCls;
  logic rawW, rawF;

  always_ff @(posedge clk) begin
    if (rst)             ir <= NOP_WORD;
    else if (ctl.loadIr) ir <= fetchWord;
  end

  always_comb begin
    rawCls = CLS_NOP;
    rawW   = 1'b0;
    rawF   = 1'b0;
    unique case (ir[13:12])
      2'b00: begin
        if (ir[11:8] != 4'd0 || ir[7]) begin
          rawCls = CLS_BYTE;
          rawW   = ~ir[7];
          rawF   = ir[7];
        end
      end
      2'b01: begin
        rawCls = CLS_BIT;
        rawF   = ~ir[11];
      end
      2'b10: rawCls = CLS_JUMP;
      2'b11: begin
        if (ir[11:8] != LIT_HOLE) begin
          rawCls = CLS_LIT;
          rawW   = 1'b1;
        end
      end
      default: rawCls = CLS_NOP;
    endcase
  end

  assign fileAddr  = ir[ADDR_W-1:0];
  assign bitPos    = ir[9:7];
  assign destFile  = ir[7];
  assign literal   = (ir[13:12] == 2'b10) ? ir[LIT_W-1:0] : {3'b000, ir[7:0]};
  assign insnClass = ctl.squash ? CLS_NOP : rawCls;
  assign wrW       = rawW & ~ctl.squash;
  assign wrFile    = rawF & ~ctl.squash;

  // R2: latched word only changes on the phase-4 load
  p_ir_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !ctl.loadIr |=> $stable(ir));
  // R8: squashed cycle writes nothing
  p_squash_r8: assert property (@(posedge clk) disable iff (rst)
    ctl.squash |-> (insnClass == CLS_NOP && !wrW && !wrFile));
  // R4: never both destinations
  p_excl_r4: assert property (@(posedge clk) disable iff (rst)
    !(wrW && wrFile));
  // R6: literal class always targets W
  p_lit_w_r6: assert property (@(posedge clk) disable iff (rst)
    (insnClass == CLS_LIT) |-> (wrW && !wrFile));
endmodule

// File: rtl/insn_cycle_seq.sv
module insn_cycle_seq
  import insn_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic [13:0] fetchWord,
  input  logic        flushReq,
  output logic [3:0]  phaseStb,
  output logic [2:0]  insnClass,
  output logic [6:0]  fileAddr,
  output logic [2:0]  bitPos,
  output logic [10:0] literal,
  output logic        destFile,
  output logic        wrW,
  output logic        wrFile,
  output logic        flushCycle
);
  seq_ctl_t ctl;

  seq_ctrl #(.NUM_PH(PHASES)) u_ctrl (
    .clk(clk), .rst(rst), .flushReq(flushReq),
    .phaseStb(phaseStb), .ctl(ctl)
  );

  seq_dpath u_dpath (
    .clk(clk), .rst(rst), .fetchWord(fetchWord), .ctl(ctl),
    .insnClass(insnClass), .fileAddr(fileAddr), .bitPos(bitPos),
    .literal(literal), .destFile(destFile), .wrW(wrW), .wrFile(wrFile)
  );

  assign flushCycle = ctl.squash;

  // R9: flush indication never set right after reset
  p_reset_flush_r9: assert property (@(posedge clk)
    $past(rst) |-> !flushCycle);
endmodule

// File: tb/test_insn_cycle_seq.sv
module test_insn_cycle_seq;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG_CYCLES = 100000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [13:0] fetchWord = '0;
  logic        flushReq = 1'b0;
  logic [3:0]  phaseStb;
  logic [2:0]  insnClass;
  logic [6:0]  fileAddr;
  logic [2:0]  bitPos;
  logic [10:0] literal;
  logic        destFile, wrW, wrFile, flushCycle;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [2:0]  eCls;
  logic        eW, eF;
  logic [10:0] eLit;

  insn_cycle_seq i_insn_cycle_seq (
    .clk(clk), .rst(rst), .fetchWord(fetchWord), .flushReq(flushReq),
    .phaseStb(phaseStb), .insnClass(insnClass), .fileAddr(fileAddr),
    .bitPos(bitPos), .literal(literal), .destFile(destFile),
    .wrW(wrW), .wrFile(wrFile), .flushCycle(flushCycle)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic expect_word(logic [13:0] w, logic fl);
    eCls = 3'd0; eW = 0; eF = 0;
    case (w[13:12])
      2'b00: if (w[11:8] != 0 || w[7]) begin eCls = 3'd1; eW = ~w[7]; eF = w[7]; end
      2'b01: begin eCls = 3'd2; eF = ~w[11]; end
      2'b10: eCls = 3'd4;
      default: if (w[11:8] != 4'b1011) begin eCls = 3'd3; eW = 1; end
    endcase
    eLit = (w[13:12] == 2'b10) ? w[10:0] : {3'b000, w[7:0]};
    if (fl) begin eCls = 3'd0; eW = 0; eF = 0; end
  endtask

  task automatic check_outputs(logic [13:0] w, logic fl, string tag);
    expect_word(w, fl);
    check({tag, " R3 class"}, insnClass, eCls);
    check({tag, " R4 wrW"}, wrW, eW);
    check({tag, " R5 wrFile"}, wrFile, eF);
    check({tag, " R4 fileAddr"}, fileAddr, w[6:0]);
    check({tag, " R4 destFile"}, destFile, w[7]);
    check({tag, " R5 bitPos"}, bitPos, w[9:7]);
    check({tag, " R6 literal"}, literal, eLit);
    check({tag, " R8 flushCycle"}, flushCycle, fl);
  endtask

  // Entered just after a falling edge in phase 1; leaves at the next phase 1.
  task automatic run_cycle(logic [13:0] w, logic fP4, logic fOth,
                           logic [13:0] prevW, logic prevFl);
    fetchWord = 14'($urandom);
    flushReq  = fOth;
    check("R1 phase1", phaseStb, 4'b0001);
    @(negedge clk);
    check("R1 phase2", phaseStb, 4'b0010);
    fetchWord = ~w;
    @(negedge clk);
    check("R1 phase3", phaseStb, 4'b0100);
    check_outputs(prevW, prevFl, "R2 hold");
    @(negedge clk);
    check("R1 phase4", phaseStb, 4'b1000);
    fetchWord = w;
    flushReq  = fP4;
    @(negedge clk);
    flushReq  = 1'b0;
    check_outputs(w, fP4, "R2 load");
  endtask

  logic [13:0] lastW = '0;
  logic        lastFl = 0;

  task automatic step(logic [13:0] w, logic fP4, logic fOth);
    run_cycle(w, fP4, fOth, lastW, lastFl);
    lastW = w;
    lastFl = fP4;
  endtask

  initial begin : watchdog
    for (int i = 0; i < WATCHDOG_CYCLES; i++) begin
      @(posedge clk);
      if (done) disable watchdog;
    end
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    rst = 1'b1;
    fetchWord = 14'h3FFF;
    flushReq = 1'b1;
    repeat (3) @(negedge clk);
    check("R9 reset phase", phaseStb, 4'b0001);
    check("R9 reset class", insnClass, 3'd0);
    check("R9 reset writes", {wrW, wrFile}, 2'b00);
    check("R9 reset flush", flushCycle, 1'b0);
    rst = 1'b0;
    flushReq = 1'b0;

    // directed: each class and field
    step(14'b00_0111_1_0101010, 0, 0);   // byte to file
    step(14'b00_0111_0_1100110, 0, 0);   // byte to W
    step(14'b00_0000_1_0011001, 0, 0);   // byte class, opcode 0, d=1
    step(14'b00_0000_0_1111111, 0, 0);   // R7 undefined
    step(14'b01_00_101_0001111, 0, 0);   // R5 bit write
    step(14'b01_01_011_0000001, 0, 0);   // R5 bit write
    step(14'b01_10_111_1110000, 0, 0);   // R5 bit test, no write
    step(14'b01_11_000_0101010, 0, 0);   // R5 bit test, no write
    step(14'b10_0_10110011001, 0, 0);    // R6 jump
    step(14'b10_1_01001100110, 0, 0);    // R6 jump
    step(14'b11_0000_10100101, 0, 0);    // R6 literal
    step(14'b11_1011_11111111, 0, 0);    // R7 literal hole
    step(14'b11_1110_00000001, 0, 0);    // R6 literal
    // R8: flush at phase 4 squashes, flush elsewhere ignored
    step(14'b00_0111_1_0000011, 1, 0);
    step(14'b11_0000_01010101, 1, 1);
    step(14'b00_0111_0_0000011, 0, 1);
    step(14'b01_00_001_0000010, 0, 1);

    // random mix
    for (int n = 0; n < 300; n++) begin
      logic [13:0] w;
      w = 14'($urandom);
      step(w, ($urandom % 4) == 0, 1'($urandom));
    end

    // R9: reset in mid-cycle
    step(14'b00_0111_1_0101010, 1, 0);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R9 mid reset phase", phaseStb, 4'b0001);
    check("R9 mid reset class", insnClass, 3'd0);
    check("R9 mid reset writes", {wrW, wrFile}, 2'b00);
    check("R9 mid reset flush", flushCycle, 1'b0);
    rst = 1'b0;
    lastW = '0;
    lastFl = 0;
    step(14'b11_0001_00110011, 0, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule